// File: doc/BRIEF.md
# Self-Clocked Converter Frame Receiver

This block is the slave end of a serial link to an analog-to-digital converter that acts as the serial master. The converter drives the bit clock and an active-low frame strobe. It lowers the strobe by itself shortly after it sees the rising edge of the conversion-start pulse. The block produces that pulse from the system clock when the host asks for a conversion. During each frame the block shifts in the converter's result and, over the same bit clocks, shifts out a control word to the converter's data input. Both words are 16 bits and travel most significant bit first. Result and control word move during the conversion, so the converter's end-of-conversion flag is not needed.

The block samples received bits on the rising edge of the bit clock and launches transmitted bits on the falling edge. The bit clock idles low. A frame that ends before all 16 bits have arrived is discarded. Edges beyond the sixteenth in one frame are ignored. A completed word crosses into the system clock domain through a toggle handshake and appears there as a one-cycle valid strobe with the word beside it.

Top module: `adc_frame_rx`

## Requirements
- R1: After reset, conv_start, result_valid and result_data are all 0. While sync_n is high, adc_din carries bit 15 of ctrl_word.
- R2: A conv_req seen high on a sys_clk edge while no pulse is active drives conv_start high from the next cycle for exactly PULSE_CYC cycles (default 4).
- R3: A conv_req that arrives while conv_start is high has no effect: the running pulse is neither extended nor restarted.
- R4: While sync_n is low, adc_dout is sampled on each rising sclk edge. The first bit sampled is bit 15 of the word, and the 16th bit sampled is bit 0.
- R5: During a frame, adc_din presents ctrl_word bit 15 before the first rising sclk edge. After the k-th falling sclk edge it presents bit 15-k.
- R6: Each completed frame gives exactly one result_valid pulse, one sys_clk cycle long. result_data takes the new word in that cycle and holds it at all other times.
- R7: A frame in which sync_n rises after fewer than 16 rising sclk edges produces no result_valid.
- R8: Rising sclk edges after the 16th in a frame do not change the delivered word.
- R9: result_valid rises within 6 sys_clk cycles after the 16th rising sclk edge of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| conv_req | input | 1 | Request for one conversion-start pulse |
| ctrl_word | input | 16 | Control word sent to the converter in each frame |
| conv_start | output | 1 | Conversion-start pulse to the converter |
| sclk | input | 1 | Bit clock driven by the converter |
| sync_n | input | 1 | Active-low frame strobe driven by the converter |
| adc_dout | input | 1 | Serial result from the converter |
| adc_din | output | 1 | Serial control word to the converter |
| result_data | output | 16 | Last completed result, in the system domain |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that ctrl_word is quasi-static. It may change only while sync_n is high. They also assume that two frames finish no closer together than the handshake latency of a few sys_clk cycles. The stimulus changes the control word only between frames. It leaves at least ten system cycles after each frame, and its bit clock is five system cycles long. The stimulus moves adc_dout and samples adc_din in the low phase of sclk, away from the rising edge on which the converter side samples. Short and long frames are included to reach the discard and truncation cases.

// File: rtl/adc_frame_rx_pkg.sv
package adc_frame_rx_pkg;
   localparam int unsigned WORD_W_DEF    = 16;
   localparam int unsigned SYNC_STG_DEF  = 2;
   localparam int unsigned PULSE_CYC_DEF = 4;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/adc_frame_rx_tx.sv
module adc_frame_rx_tx #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              sclk,
   input  logic              sync_n,
   input  logic [WORD_W-1:0] ctrl_word,
   output logic              adc_din
);
   localparam int unsigned IW = adc_frame_rx_pkg::cnt_bits(WORD_W);

   logic [IW-1:0] tx_idx;

   always_ff @(negedge sclk or posedge sync_n) begin
      if (sync_n)
         tx_idx <= '0;
      else if (tx_idx < IW'(WORD_W))
         tx_idx <= tx_idx + 1'b1;
   end

   always_comb begin
      if (tx_idx < IW'(WORD_W))
         adc_din = ctrl_word[IW'(WORD_W - 1) - tx_idx];
      else
         adc_din = 1'b0;
   end
endmodule

// File: rtl/adc_frame_rx_shift.sv
module adc_frame_rx_shift #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              sclk,
   input  logic              sync_n,
   input  logic              rst_n,
   input  logic              adc_dout,
   output logic [WORD_W-1:0] word_q,
   output logic              word_tgl
);
   localparam int unsigned CW = adc_frame_rx_pkg::cnt_bits(WORD_W);

   logic [CW-1:0]     bit_cnt;
   logic [WORD_W-1:0] shreg;

   always_ff @(posedge sclk or posedge sync_n) begin
      if (sync_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (bit_cnt < CW'(WORD_W)) begin
         bit_cnt <= bit_cnt + 1'b1;
         shreg   <= {shreg[WORD_W-2:0], adc_dout};
      end
   end

   wire last_bit = !sync_n && (bit_cnt == CW'(WORD_W - 1));

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         word_tgl <= 1'b0;
      end else if (last_bit) begin
         word_q   <= {shreg[WORD_W-2:0], adc_dout};
         word_tgl <= ~word_tgl;
      end
   end

   // R8: once a frame is complete, no further edge in it flips the toggle
   assert_no_extra_word_R8: assert property (@(posedge sclk) disable iff (!rst_n || sync_n)
      (bit_cnt == CW'(WORD_W)) |=> $stable(word_tgl));
endmodule

// File: rtl/adc_frame_rx_cdc.sv
module adc_frame_rx_cdc #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              sys_clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_q,
   input  logic              word_tgl,
   output logic [WORD_W-1:0] result_data,
   output logic              result_valid
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   tgl_seen;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("SYNC_STAGES must be at least 2");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         always_ff @(posedge sys_clk or negedge rst_n) begin
            if (!rst_n)
               sync_q[s] <= 1'b0;
            else if (s == 0)
               sync_q[s] <= word_tgl;
            else
               sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
         end
      end
   endgenerate

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_seen     <= 1'b0;
         result_valid <= 1'b0;
         result_data  <= '0;
      end else begin
         tgl_seen     <= sync_q[SYNC_STAGES-1];
         result_valid <= sync_q[SYNC_STAGES-1] ^ tgl_seen;
         if (sync_q[SYNC_STAGES-1] ^ tgl_seen)
            result_data <= word_q;
      end
   end

   assert_valid_single_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
   assert_data_held_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
      !result_valid |-> $stable(result_data));
endmodule

// File: rtl/adc_frame_rx_cstart.sv
module adc_frame_rx_cstart #(
   parameter int unsigned PULSE_CYC = 4
) (
   input  logic sys_clk,
   input  logic rst_n,
   input  logic conv_req,
   output logic conv_start
);
   localparam int unsigned PW = adc_frame_rx_pkg::cnt_bits(PULSE_CYC);

   logic [PW-1:0] left_q;

   generate
      if (PULSE_CYC < 1) begin : g_bad
         $error("PULSE_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (left_q != '0)
         left_q <= left_q - 1'b1;
      else if (conv_req)
         left_q <= PW'(PULSE_CYC);
   end

   assign conv_start = (left_q != '0);

   logic [PW:0] hi_len;
   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n)
         hi_len <= '0;
      else if (conv_start)
         hi_len <= hi_len + 1'b1;
      else
         hi_len <= '0;
   end

   assert_pulse_max_R3: assert property (@(posedge sys_clk) disable iff (!rst_n)
      hi_len <= (PW+1)'(PULSE_CYC));
   assert_pulse_starts_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (!conv_start && conv_req) |=> conv_start);
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
   parameter int unsigned WORD_W      = adc_frame_rx_pkg::WORD_W_DEF,
   parameter int unsigned SYNC_STAGES = adc_frame_rx_pkg::SYNC_STG_DEF,
   parameter int unsigned PULSE_CYC   = adc_frame_rx_pkg::PULSE_CYC_DEF
) (
   input  logic              sys_clk,
   input  logic              rst_n,
   input  logic              conv_req,
   input  logic [WORD_W-1:0] ctrl_word,
   output logic              conv_start,
   input  logic              sclk,
   input  logic              sync_n,
   input  logic              adc_dout,
   output logic              adc_din,
   output logic [WORD_W-1:0] result_data,
   output logic              result_valid
);
   generate
      if (WORD_W < 2) begin : g_bad
         $error("WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] word_q;
   logic              word_tgl;

   adc_frame_rx_cstart #(.PULSE_CYC(PULSE_CYC)) cstart_i (
      .sys_clk(sys_clk), .rst_n(rst_n), .conv_req(conv_req), .conv_start(conv_start));

   adc_frame_rx_tx #(.WORD_W(WORD_W)) tx_i (
      .sclk(sclk), .sync_n(sync_n), .ctrl_word(ctrl_word), .adc_din(adc_din));

   adc_frame_rx_shift #(.WORD_W(WORD_W)) shift_i (
      .sclk(sclk), .sync_n(sync_n), .rst_n(rst_n), .adc_dout(adc_dout),
      .word_q(word_q), .word_tgl(word_tgl));

   adc_frame_rx_cdc #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) cdc_i (
      .sys_clk(sys_clk), .rst_n(rst_n), .word_q(word_q), .word_tgl(word_tgl),
      .result_data(result_data), .result_valid(result_valid));
endmodule

// File: tb/adc_frame_rx_tb_top.sv
`timescale 1ns/1ps
module adc_frame_rx_tb_top;
   localparam int PULSE = 4;

   logic        sys_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_req = 1'b0;
   logic [15:0] ctrl_word = 16'h0000;
   logic        conv_start;
   logic        sclk = 1'b0;
   logic        sync_n = 1'b1;
   logic        adc_dout = 1'b0;
   logic        adc_din;
   logic [15:0] result_data;
   logic        result_valid;

   int errors = 0;
   int checks = 0;
   logic [15:0] exp_q[$];
   int   hi_cnt = 0;
   int   since_last = 0;
   bit   window_on = 0;
   logic prev_valid = 1'b0;
   bit   done = 0;

   always #4 sys_clk = ~sys_clk;

   adc_frame_rx dut_i (
      .sys_clk(sys_clk), .rst_n(rst_n), .conv_req(conv_req), .ctrl_word(ctrl_word),
      .conv_start(conv_start), .sclk(sclk), .sync_n(sync_n), .adc_dout(adc_dout),
      .adc_din(adc_din), .result_data(result_data), .result_valid(result_valid));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: scoreboard, pulse width, latency
   always @(negedge sys_clk) begin
      if (rst_n && !done) begin
         if (conv_start) hi_cnt++;
         else if (hi_cnt != 0) begin
            check("R2/R3 pulse width", hi_cnt, PULSE);
            hi_cnt = 0;
         end
         if (window_on) since_last++;
         if (result_valid) begin
            check("R6 single-cycle valid", {31'b0, prev_valid}, 0);
            if (exp_q.size() == 0) check("R7 unexpected valid", 1, 0);
            else begin
               check("R4/R8 word", result_data, exp_q.pop_front());
               check("R9 latency", {31'b0, since_last <= 6}, 1);
            end
            window_on = 0;
         end
         prev_valid = result_valid;
      end
   end

   task automatic frame(input logic [15:0] ctrl, input logic [15:0] data, input int nbits);
      ctrl_word = ctrl;
      #20;
      check("R5 idle msb", adc_din, ctrl[15]);
      sync_n = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         adc_dout = (i < 16) ? data[15-i] : ~data[0];
         #10;
         if (i < 16) check("R5 tx bit", adc_din, ctrl[15-i]);
         if (i == 15) begin
            exp_q.push_back(data);
            since_last = 0;
            window_on = 1;
         end
         sclk = 1'b1;
         #20;
         sclk = 1'b0;
         #10;
      end
      #10;
      sync_n = 1'b1;
      #120;
      check("R7/R6 queue drained", exp_q.size(), 0);
   endtask

   task automatic request_conv(input bit second);
      @(negedge sys_clk);
      conv_req = 1'b1;
      @(negedge sys_clk);
      conv_req = 1'b0;
      if (second) begin
         @(negedge sys_clk);
         conv_req = 1'b1; // R3: while pulse active
         @(negedge sys_clk);
         conv_req = 1'b0;
      end
      wait (conv_start == 1'b0);
      #20;
   endtask

   initial begin
      #20;
      check("R1 conv_start", conv_start, 0);
      check("R1 result_valid", result_valid, 0);
      check("R1 result_data", result_data, 0);
      check("R1 adc_din", adc_din, 0);
      @(negedge sys_clk);
      rst_n = 1'b1;
      #40;
      request_conv(0);
      frame(16'hC35A, 16'hA5C3, 16);
      request_conv(1);
      frame(16'h8001, 16'hFFFF, 16);
      request_conv(0);
      frame(16'hFFFF, 16'h0000, 16);
      frame(16'h1234, 16'h8001, 10); // R7 short frame
      check("R6 data held after short", result_data, 16'h0000);
      frame(16'h0F0F, 16'h6DB7, 20); // R8 long frame
      frame(16'h7FFE, 16'h1357, 16);
      #100;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule